// File: doc/BRIEF.md
# Barrel Shifter with Carry Flag

This block is the shift unit of an integer execution pipeline. It takes a 32-bit operand, a shift count and a two-bit operation code. It performs a logical left shift, a logical right shift or an arithmetic right shift. Along with the result it produces zero, sign, carry and overflow condition flags. The count may arrive from a register or from a zero-extended immediate. Both forms use the same port and give the same flags.

An operation is presented by raising `in_valid` for one cycle. The result and flags appear registered on the following cycle, together with a one-cycle `out_valid` pulse. The carry flag holds the last bit pushed out of the word. A count of zero moves nothing, so in that case the carry is cleared rather than taken from a bit outside the word.

Top module: `bsh_top`

## Requirements
- R1: Operation code 2'b00 is a logical left shift: the result is the operand shifted left by n, where n is the count, and the vacated low bits are 0.
- R2: Operation codes 2'b01 and 2'b11 are a logical right shift: the result is the operand shifted right by n, and the vacated high bits are 0.
- R3: Operation code 2'b10 is an arithmetic right shift: the vacated high bits are copies of operand bit 31.
- R4: Only bits [4:0] of `in_count` form n. All higher count bits are ignored.
- R5: When n is 0, the result equals the operand and the carry flag is 0 for every operation code.
- R6: For both right shifts with n > 0, the carry flag equals operand bit n-1.
- R7: For the left shift with n > 0, the carry flag equals operand bit 32-n.
- R8: The zero flag is 1 exactly when all 32 result bits are 0.
- R9: The sign flag equals bit 31 of the result.
- R10: The overflow flag is 0 after every shift.
- R11: Result and flags appear with `out_valid` high in the cycle after `in_valid` is sampled high. `out_valid` is low in any cycle that does not follow an accepted operation. While reset is held, every output is 0.
- R12: When `in_valid` is low, the result and all flags keep their previous values, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| in_valid | input | 1 | Operation strobe |
| in_op | input | 2 | Operation code (00 left, 01/11 logical right, 10 arithmetic right) |
| in_operand | input | 32 | Value to shift |
| in_count | input | 32 | Shift count; only bits [4:0] are used |
| out_valid | output | 1 | One-cycle pulse marking a new result |
| out_result | output | 32 | Shifted value |
| out_zero | output | 1 | Result is all zeros |
| out_sign | output | 1 | Bit 31 of the result |
| out_carry | output | 1 | Last bit shifted out, 0 for a zero count |
| out_ovf | output | 1 | Overflow flag, always cleared |

## Verification
The bench sweeps every count from 0 to 31 for each operation code. A design that read bit n-1 or bit 32-n without guarding the zero count would show a spurious or undefined carry on count 0. A design that took the left-shift carry from the wrong end would fail the sweep at every count except the middle one. Counts with high bits set are used to catch a design that decodes more than five bits and so shifts everything out. A negative operand under arithmetic shift exposes zero-filling. Idle cycles with changing inputs catch a register that loads without the strobe.

// File: rtl/bsh_pkg.sv
package bsh_pkg;
  // Operation select encoding; the left/right split is decoded by the top.
  typedef enum logic [1:0] {
    SH_LL = 2'b00,
    SH_RL = 2'b01,
    SH_RA = 2'b10,
    SH_RX = 2'b11
  } sh_op_e;
endpackage

// File: rtl/bsh_mirror.sv
// Conditional bit reversal, used to map a left shift onto the right shifter.
module bsh_mirror #(
  parameter int W = 32
) (
  input  logic         en,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] rev;

  for (genvar i = 0; i < W; i++) begin : g_rev
    assign rev[i] = din[W-1-i];
  end

  assign dout = en ? rev : din;
endmodule

// File: rtl/bsh_rshift_core.sv
// Logarithmic right shifter over W+1 bits (operand plus a guard bit below it).
// After shifting by n the guard position holds the last bit moved out, and
// holds the zero guard itself when n is 0.
module bsh_rshift_core #(
  parameter int W    = 32,
  parameter int SH_W = 5
) (
  input  logic [W:0]      vec,
  input  logic            fill,
  input  logic [SH_W-1:0] amt,
  output logic [W:0]      shifted
);
  for (genvar s = 0; s < SH_W; s++) begin : g_st
    localparam int K = 1 << s;
    logic [W:0] src;
    logic [W:0] dst;
    if (s == 0) begin : g_first
      assign src = vec;
    end else begin : g_next
      assign src = g_st[s-1].dst;
    end
    assign dst = amt[s] ? {{K{fill}}, src[W:K]} : src;
  end

  assign shifted = g_st[SH_W-1].dst;
endmodule

// File: rtl/bsh_flags.sv
module bsh_flags #(
  parameter int W = 32
) (
  input  logic [W-1:0] res,
  output logic         zero,
  output logic         sign
);
  assign zero = (res == '0);
  assign sign = res[W-1];
endmodule

// File: rtl/bsh_top.sv
module bsh_top #(
  parameter int DATA_W   = 32,
  parameter int CNT_IN_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [1:0]          in_op,
  input  logic [DATA_W-1:0]   in_operand,
  input  logic [CNT_IN_W-1:0] in_count,
  output logic                out_valid,
  output logic [DATA_W-1:0]   out_result,
  output logic                out_zero,
  output logic                out_sign,
  output logic                out_carry,
  output logic                out_ovf
);
  import bsh_pkg::*;

  localparam int SH_W = $clog2(DATA_W);

  // Reset: asserted asynchronously, released after two clock edges.
  logic [1:0] rst_pipe;
  logic       rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_q_n = rst_pipe[1];

  // Decode.
  sh_op_e          op_e;
  logic            go_left;
  logic            go_arith;
  logic [SH_W-1:0] amt;
  logic            unused_cnt;

  assign op_e       = sh_op_e'(in_op);
  assign go_left    = (op_e == SH_LL);
  assign go_arith   = (op_e == SH_RA);
  assign amt        = in_count[SH_W-1:0];
  assign unused_cnt = ^in_count[CNT_IN_W-1:SH_W];

  // Datapath.
  logic [DATA_W-1:0] pre;
  logic [DATA_W:0]   shifted;
  logic [DATA_W-1:0] post;
  logic              fill;
  logic              c_new;
  logic              z_new;
  logic              s_new;

  bsh_mirror #(.W(DATA_W)) u_pre (
    .en  (go_left),
    .din (in_operand),
    .dout(pre)
  );

  assign fill = go_arith & in_operand[DATA_W-1];

  bsh_rshift_core #(.W(DATA_W), .SH_W(SH_W)) u_core (
    .vec    ({pre, 1'b0}),
    .fill   (fill),
    .amt    (amt),
    .shifted(shifted)
  );

  bsh_mirror #(.W(DATA_W)) u_post (
    .en  (go_left),
    .din (shifted[DATA_W:1]),
    .dout(post)
  );

  assign c_new = shifted[0];

  bsh_flags #(.W(DATA_W)) u_flags (
    .res (post),
    .zero(z_new),
    .sign(s_new)
  );

  // Output stage: next-state logic.
  logic              vld_d;
  logic [DATA_W-1:0] res_d;
  logic              z_d, s_d, c_d, ov_d;

  always_comb begin
    vld_d = in_valid;
    res_d = out_result;
    z_d   = out_zero;
    s_d   = out_sign;
    c_d   = out_carry;
    ov_d  = out_ovf;
    if (in_valid) begin
      res_d = post;
      z_d   = z_new;
      s_d   = s_new;
      c_d   = c_new;
      ov_d  = 1'b0;
    end
  end

  // Output stage: registers.
  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      out_valid  <= 1'b0;
      out_result <= '0;
      out_zero   <= 1'b0;
      out_sign   <= 1'b0;
      out_carry  <= 1'b0;
      out_ovf    <= 1'b0;
    end else begin
      out_valid  <= vld_d;
      out_result <= res_d;
      out_zero   <= z_d;
      out_sign   <= s_d;
      out_carry  <= c_d;
      out_ovf    <= ov_d;
    end
  end
endmodule

// File: rtl/bsh_checker.sv
module bsh_checker #(
  parameter int DATA_W   = 32,
  parameter int CNT_IN_W = 32
) (
  input logic                clk,
  input logic                rst_q_n,
  input logic                in_valid,
  input logic [1:0]          in_op,
  input logic [DATA_W-1:0]   in_operand,
  input logic [CNT_IN_W-1:0] in_count,
  input logic                out_valid,
  input logic [DATA_W-1:0]   out_result,
  input logic                out_zero,
  input logic                out_sign,
  input logic                out_carry,
  input logic                out_ovf
);
  localparam int SH_W = $clog2(DATA_W);

  p_zero_count_pass_r5: assert property (@(posedge clk) disable iff (!rst_q_n)
    (in_valid && in_count[SH_W-1:0] == '0) |=> (out_result == $past(in_operand) && !out_carry));

  p_arith_keeps_sign_r3: assert property (@(posedge clk) disable iff (!rst_q_n)
    (in_valid && in_op == 2'b10) |=> (out_result[DATA_W-1] == $past(in_operand[DATA_W-1])));

  p_zero_flag_r8: assert property (@(posedge clk) disable iff (!rst_q_n)
    out_valid |-> (out_zero == (out_result == '0)));

  p_sign_flag_r9: assert property (@(posedge clk) disable iff (!rst_q_n)
    out_valid |-> (out_sign == out_result[DATA_W-1]));

  p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_q_n)
    in_valid |=> !out_ovf);

  p_valid_latency_r11: assert property (@(posedge clk) disable iff (!rst_q_n)
    in_valid |=> out_valid);

  p_valid_idle_r11: assert property (@(posedge clk) disable iff (!rst_q_n)
    !in_valid |=> !out_valid);

  p_hold_r12: assert property (@(posedge clk) disable iff (!rst_q_n)
    !in_valid |=> ($stable(out_result) && $stable(out_carry) && $stable(out_zero) && $stable(out_sign)));
endmodule

bind bsh_top bsh_checker #(.DATA_W(DATA_W), .CNT_IN_W(CNT_IN_W)) u_chk (
  .clk       (clk),
  .rst_q_n   (rst_q_n),
  .in_valid  (in_valid),
  .in_op     (in_op),
  .in_operand(in_operand),
  .in_count  (in_count),
  .out_valid (out_valid),
  .out_result(out_result),
  .out_zero  (out_zero),
  .out_sign  (out_sign),
  .out_carry (out_carry),
  .out_ovf   (out_ovf)
);

// File: tb/bsh_top_tb.sv
module bsh_top_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [1:0]  in_op;
  logic [31:0] in_operand;
  logic [31:0] in_count;
  logic        out_valid;
  logic [31:0] out_result;
  logic        out_zero, out_sign, out_carry, out_ovf;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bsh_top dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
    .in_operand(in_operand), .in_count(in_count), .out_valid(out_valid),
    .out_result(out_result), .out_zero(out_zero), .out_sign(out_sign),
    .out_carry(out_carry), .out_ovf(out_ovf)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Reference model written from the requirements.
  task automatic model(input logic [1:0] op, input logic [31:0] a, input logic [31:0] cnt,
                       output logic [31:0] r, output logic c);
    int n;
    n = int'(cnt[4:0]);
    if (op == 2'b00) begin
      r = a << n;
      c = (n == 0) ? 1'b0 : a[32-n];
    end else if (op == 2'b10) begin
      r = 32'($signed(a) >>> n);
      c = (n == 0) ? 1'b0 : a[n-1];
    end else begin
      r = a >> n;
      c = (n == 0) ? 1'b0 : a[n-1];
    end
  endtask

  // Issue one operation and check every output one cycle later.
  task automatic run_op(input string req, input logic [1:0] op, input logic [31:0] a, input logic [31:0] cnt);
    logic [31:0] er;
    logic        ec;
    model(op, a, cnt, er, ec);
    @(negedge clk);
    in_op = op; in_operand = a; in_count = cnt; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R11", "valid", 32'(out_valid), 32'd1);
    chk(req, "result", out_result, er);
    chk((cnt[4:0] == 5'd0) ? "R5" : ((op == 2'b00) ? "R7" : "R6"), "carry", 32'(out_carry), 32'(ec));
    chk("R8", "zero", 32'(out_zero), 32'(er == 32'd0));
    chk("R9", "sign", 32'(out_sign), 32'(er[31]));
    chk("R10", "ovf", 32'(out_ovf), 32'd0);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; in_valid = 1'b0; in_op = 2'b00; in_operand = '0; in_count = '0;
    repeat (3) @(negedge clk);
    chk("R11", "reset valid", 32'(out_valid), 32'd0);
    chk("R11", "reset result", out_result, 32'd0);
    chk("R11", "reset flags", {28'd0, out_zero, out_sign, out_carry, out_ovf}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_basic;
    run_op("R1", 2'b00, 32'h8000_0001, 32'd1);   // carry out of bit 31
    run_op("R1", 2'b00, 32'h1234_5678, 32'd4);
    run_op("R2", 2'b01, 32'h8000_0001, 32'd1);   // carry from bit 0
    run_op("R2", 2'b11, 32'hF000_0000, 32'd28);
    run_op("R3", 2'b10, 32'h8000_0000, 32'd31);  // all ones
    run_op("R3", 2'b10, 32'h7FFF_FFFF, 32'd30);
    run_op("R8", 2'b01, 32'h0000_0001, 32'd1);   // result zero, carry 1
  endtask

  task automatic t_zero_count;
    for (int op = 0; op < 4; op++) begin
      run_op("R5", 2'(op), 32'hFFFF_FFFF, 32'd0);
      run_op("R5", 2'(op), 32'h0000_0000, 32'd0);
    end
  endtask

  task automatic t_count_mask;
    run_op("R4", 2'b00, 32'h0000_00FF, 32'h0000_0024);  // acts as 4
    run_op("R4", 2'b01, 32'hA5A5_A5A5, 32'hFFFF_FFE0);  // acts as 0
    run_op("R4", 2'b10, 32'h8765_4321, 32'h8000_0021);  // acts as 1
  endtask

  task automatic t_sweep;
    for (int op = 0; op < 4; op++) begin
      for (int n = 0; n < 32; n++) begin
        run_op((op == 0) ? "R1" : ((op == 2) ? "R3" : "R2"), 2'(op), 32'hC3A5_5A3C ^ (32'h1 << n), 32'(n));
      end
    end
  endtask

  task automatic t_hold;
    logic [31:0] er;
    logic        ec;
    run_op("R12", 2'b00, 32'h0F0F_0F0F, 32'd3);
    model(2'b00, 32'h0F0F_0F0F, 32'd3, er, ec);
    @(negedge clk);
    in_op = 2'b01; in_operand = 32'h0000_0000; in_count = 32'd0; in_valid = 1'b0;
    @(negedge clk);
    chk("R11", "idle valid", 32'(out_valid), 32'd0);
    chk("R12", "held result", out_result, er);
    chk("R12", "held flags", {29'd0, out_zero, out_sign, out_carry}, {29'd0, er == 32'd0, er[31], ec});
  endtask

  initial begin
    t_reset();
    t_basic();
    t_zero_count();
    t_count_mask();
    t_sweep();
    t_hold();
    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule